// File: doc/BRIEF.md
# Thermal Sensor Code Converter

This block maps between a temperature in degrees Celsius and the raw 8-bit code of an on-die thermal sensor, in either direction. Each die carries fused trim codes measured at two reference temperatures. The block takes the fused trim word once, checks it, and falls back to a configured spare word where the fuse looks blank or implausible. It then runs conversions on request with one of three calibration schemes: a linear fit through two trim points, a single-point shift, or a fixed offset.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream. The request side is ready only when the block is idle. A result stays on the output, unchanged, until it is accepted, and no new request is taken before then. The two-point scheme needs a true division, which a serial restoring divider performs over 2·DW cycles. The other schemes finish in two cycles. Configuration pins are plain and are sampled only on the load strobe.

Top module: `thermcode_conv`

## Requirements
- R1: On a `cfg_load` pulse seen while `busy` is low, the block captures the calibration mode, trim codes, reference temperatures and offset. Every later conversion uses only the captured values. A change on the configuration pins without a load, or a load pulse while `busy` is high, has no effect on results.
- R2: The low trim code E1 is `cfg_fuse[7:0]`. If it is zero, below `cfg_fuse_min` or above `cfg_fuse_max` (limits inclusive), `cfg_fallback[7:0]` is used instead.
- R3: The high trim code E2 is `cfg_fuse[15:8]` (the byte at shift E2_SHIFT, default 8). If it is zero, `cfg_fallback[15:8]` is used instead.
- R4: Fixed-offset mode (`cfg_mode` 2'b00 or 2'b11): with `req_dir`=0 (temperature to code) the result is operand + offset; with `req_dir`=1 (code to temperature) it is operand − offset.
- R5: One-point mode (`cfg_mode` 2'b01): temperature to code gives operand + E1 − T1, and code to temperature gives operand − E1 + T1. T1 is `cfg_ref_lo`.
- R6: Two-point mode (`cfg_mode` 2'b10), temperature to code: (operand − T1)·(E2 − E1)/(T2 − T1) + E1. The quotient is truncated toward zero. T2 is `cfg_ref_hi`.
- R7: Two-point mode, code to temperature: (operand − E1)·(T2 − T1)/(E2 − E1) + T1, with the quotient truncated toward zero.
- R8: Every result is clamped to 0..255. A negative value gives 0 and a value above 255 gives 255.
- R9: In two-point mode a zero divisor (E2 = E1 for code to temperature, T2 = T1 for temperature to code) skips the division. The response then carries `rsp_div_err`=1 and `rsp_data`=0.
- R10: `rsp_range_err` is 1 exactly when `req_dir`=1 and the operand lies outside 75..175 inclusive. Requests with `req_dir`=0 never set it. The result is still computed.
- R11: `req_ready` is low from the cycle after an accepted request until the response has been accepted. `rsp_valid` rises one cycle after the divider completes. A response that is not accepted holds its data and flags.
- R12: After reset, `req_ready`=1, `rsp_valid`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture configuration and trim (honoured when idle) |
| cfg_mode | input | 2 | 00 fixed offset, 01 one-point, 10 two-point, 11 fixed offset |
| cfg_fuse | input | 16 | Fused trim word: E1 in [7:0], E2 in [15:8] |
| cfg_fallback | input | 16 | Spare trim word, same layout |
| cfg_fuse_min | input | 8 | Lowest valid E1 |
| cfg_fuse_max | input | 8 | Highest valid E1 |
| cfg_ref_lo | input | 8 | Reference temperature T1 |
| cfg_ref_hi | input | 8 | Reference temperature T2 |
| cfg_offset | input | 8 | Offset for fixed-offset mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_dir | input | 1 | 0 temperature to code, 1 code to temperature |
| req_operand | input | 8 | Value to convert |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 8 | Converted, clamped value |
| rsp_range_err | output | 1 | Raw code outside the valid window |
| rsp_div_err | output | 1 | Two-point divisor was zero |
| busy | output | 1 | Conversion in flight or result waiting |

## Verification
The assertions assume the request fields matter only in the cycle a request is accepted. They also assume `rsp_ready` may toggle freely, including while a result waits, and that configuration pins may move at any time without a load. The bench drives `rsp_ready` in a repeating pattern that leaves results waiting for several cycles. It changes request fields only between handshakes and pulses `cfg_load` both while idle and while a conversion is in flight. The operand, mode and trim values are picked to reach truncation of negative quotients, both clamp limits, the range-window edges and both zero-divisor cases.

// File: rtl/thermcode_pkg.sv
package thermcode_pkg;

  typedef enum logic [1:0] {
    CAL_FIXED     = 2'b00,
    CAL_ONE       = 2'b01,
    CAL_TWO       = 2'b10,
    CAL_FIXED_ALT = 2'b11
  } cal_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2,
    ST_RESP = 2'd3
  } conv_state_e;

endpackage

// File: rtl/thermcode_trim.sv
module thermcode_trim #(
  parameter int DW       = 8,
  parameter int E2_SHIFT = 8,
  localparam int FW      = E2_SHIFT + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] fuse_word,
  input  logic [FW-1:0] spare_word,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  output logic [DW-1:0] e1,
  output logic [DW-1:0] e2
);

  logic [DW-1:0] lo_raw, hi_raw, lo_spare, hi_spare;
  logic          lo_good, hi_good;

  assign lo_raw   = fuse_word[DW-1:0];
  assign hi_raw   = fuse_word[E2_SHIFT +: DW];
  assign lo_spare = spare_word[DW-1:0];
  assign hi_spare = spare_word[E2_SHIFT +: DW];

  assign lo_good = (lo_raw != '0) && (lo_raw >= lim_lo) && (lo_raw <= lim_hi);
  assign hi_good = (hi_raw != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1 <= '0;
      e2 <= '0;
    end else if (load) begin
      e1 <= lo_good ? lo_raw : lo_spare;
      e2 <= hi_good ? hi_raw : hi_spare;
    end
  end

endmodule

// File: rtl/thermcode_divider.sv
module thermcode_divider #(
  parameter int DW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);

  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem, dsr;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW:0]   trial;

  assign trial = {rem, quotient[NW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      dsr      <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quotient <= dividend;
        rem      <= '0;
        dsr      <= divisor;
        cnt      <= CW'(NW);
        run      <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, dsr}) begin
          rem      <= DW'(trial - {1'b0, dsr});
          quotient <= {quotient[NW-2:0], 1'b1};
        end else begin
          rem      <= trial[DW-1:0];
          quotient <= {quotient[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/thermcode_conv.sv
module thermcode_conv
  import thermcode_pkg::*;
#(
  parameter int DW          = 8,
  parameter int E2_SHIFT    = 8,
  parameter int CODE_MIN    = 75,
  parameter int CODE_MAX    = 175,
  parameter bit RANGE_CHECK = 1'b1,
  localparam int FW         = E2_SHIFT + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_mode,
  input  logic [FW-1:0] cfg_fuse,
  input  logic [FW-1:0] cfg_fallback,
  input  logic [DW-1:0] cfg_fuse_min,
  input  logic [DW-1:0] cfg_fuse_max,
  input  logic [DW-1:0] cfg_ref_lo,
  input  logic [DW-1:0] cfg_ref_hi,
  input  logic [DW-1:0] cfg_offset,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_dir,
  input  logic [DW-1:0] req_operand,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_range_err,
  output logic          rsp_div_err,
  output logic          busy
);

  localparam int NW = 2 * DW;
  localparam int RW = 2 * DW + 3;
  localparam logic signed [RW-1:0] SAT_HI = RW'((2 ** DW) - 1);
  localparam logic [DW-1:0] WIN_LO = DW'(CODE_MIN);
  localparam logic [DW-1:0] WIN_HI = DW'(CODE_MAX);

  function automatic logic signed [RW-1:0] widen(input logic [DW-1:0] x);
    return signed'({{(RW-DW){1'b0}}, x});
  endfunction

  function automatic logic [DW-1:0] magn(input logic signed [RW-1:0] v);
    return v[RW-1] ? DW'(-v) : DW'(v);
  endfunction

  function automatic logic [DW-1:0] clamp(input logic signed [RW-1:0] v);
    if (v[RW-1])       return '0;
    else if (v > SAT_HI) return '1;
    else               return DW'(v);
  endfunction

  conv_state_e   state;
  cal_mode_e     mode_q;
  logic [DW-1:0] t1_q, t2_q, ofs_q, e1, e2;
  logic [DW-1:0] op_q;
  logic          dir_q, neg_q;
  logic [DW-1:0] data_q;
  logic          rerr_q, derr_q;
  logic          load_ok, accept;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign load_ok   = cfg_load && !busy;

  thermcode_trim #(.DW(DW), .E2_SHIFT(E2_SHIFT)) u_trim (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ok),
    .fuse_word (cfg_fuse),
    .spare_word(cfg_fallback),
    .lim_lo    (cfg_fuse_min),
    .lim_hi    (cfg_fuse_max),
    .e1        (e1),
    .e2        (e2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CAL_FIXED;
      t1_q   <= '0;
      t2_q   <= '0;
      ofs_q  <= '0;
    end else if (load_ok) begin
      mode_q <= cal_mode_e'(cfg_mode);
      t1_q   <= cfg_ref_lo;
      t2_q   <= cfg_ref_hi;
      ofs_q  <= cfg_offset;
    end
  end

  // Operand arithmetic in a signed width wide enough for any product
  logic signed [RW-1:0] op_s, e1_s, e2_s, t1_s, t2_s, ofs_s;
  logic signed [RW-1:0] a_s, b_s, d_s, base_s, direct_s, quo_s, fit_s;
  logic [DW-1:0]        a_mag, b_mag, d_mag;
  logic [NW-1:0]        dvd, quo;
  logic                 div_start, div_done, rng;

  assign op_s  = widen(op_q);
  assign e1_s  = widen(e1);
  assign e2_s  = widen(e2);
  assign t1_s  = widen(t1_q);
  assign t2_s  = widen(t2_q);
  assign ofs_s = widen(ofs_q);

  assign a_s    = dir_q ? (op_s - e1_s) : (op_s - t1_s);
  assign b_s    = dir_q ? (t2_s - t1_s) : (e2_s - e1_s);
  assign d_s    = dir_q ? (e2_s - e1_s) : (t2_s - t1_s);
  assign base_s = dir_q ? t1_s : e1_s;

  assign a_mag = magn(a_s);
  assign b_mag = magn(b_s);
  assign d_mag = magn(d_s);
  assign dvd   = NW'(a_mag) * NW'(b_mag);

  always_comb begin
    case (mode_q)
      CAL_ONE: direct_s = dir_q ? (op_s - e1_s + t1_s) : (op_s + e1_s - t1_s);
      default: direct_s = dir_q ? (op_s - ofs_s) : (op_s + ofs_s);
    endcase
  end

  assign quo_s = signed'({{(RW-NW){1'b0}}, quo});
  assign fit_s = (neg_q ? -quo_s : quo_s) + base_s;

  assign div_start = (state == ST_PREP) && (mode_q == CAL_TWO) && (d_mag != '0);

  thermcode_divider #(.DW(DW), .NW(NW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dividend(dvd),
    .divisor (d_mag),
    .done    (div_done),
    .quotient(quo)
  );

  generate
    if (RANGE_CHECK) begin : g_window
      assign rng = dir_q && ((op_q < WIN_LO) || (op_q > WIN_HI));
    end else begin : g_no_window
      assign rng = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      dir_q  <= 1'b0;
      neg_q  <= 1'b0;
      data_q <= '0;
      rerr_q <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= req_operand;
          dir_q <= req_dir;
          state <= ST_PREP;
        end
        ST_PREP: begin
          rerr_q <= rng;
          if (mode_q == CAL_TWO) begin
            if (d_mag == '0) begin
              derr_q <= 1'b1;
              data_q <= '0;
              state  <= ST_RESP;
            end else begin
              neg_q <= a_s[RW-1] ^ b_s[RW-1] ^ d_s[RW-1];
              state <= ST_DIV;
            end
          end else begin
            derr_q <= 1'b0;
            data_q <= clamp(direct_s);
            state  <= ST_RESP;
          end
        end
        ST_DIV: if (div_done) begin
          derr_q <= 1'b0;
          data_q <= clamp(fit_s);
          state  <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (state == ST_RESP);
  assign rsp_data      = data_q;
  assign rsp_range_err = rerr_q;
  assign rsp_div_err   = derr_q;

endmodule

// File: rtl/thermcode_conv_chk.sv
module thermcode_conv_chk #(
  parameter int DW          = 8,
  parameter int CODE_MIN    = 75,
  parameter int CODE_MAX    = 175,
  parameter bit RANGE_CHECK = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_dir,
  input logic [DW-1:0] req_operand,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_range_err,
  input logic          rsp_div_err,
  input logic          busy,
  input logic          div_done
);

  localparam logic [DW-1:0] WIN_LO = DW'(CODE_MIN);
  localparam logic [DW-1:0] WIN_HI = DW'(CODE_MAX);

  logic [DW-1:0] acc_op;
  logic          acc_dir;
  logic          acc_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_op  <= '0;
      acc_dir <= 1'b0;
    end else if (req_valid && req_ready) begin
      acc_op  <= req_operand;
      acc_dir <= req_dir;
    end
  end

  assign acc_out = acc_dir && ((acc_op < WIN_LO) || (acc_op > WIN_HI));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
      && $stable(rsp_range_err) && $stable(rsp_div_err));

  // R11
  done_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> rsp_valid);

  // R11
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready && !rsp_valid);

  // R9
  div_err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_div_err |-> rsp_data == '0);

  // R10
  range_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_range_err |-> acc_out);

  // R10
  range_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && RANGE_CHECK && acc_out |-> rsp_range_err);

endmodule

bind thermcode_conv thermcode_conv_chk #(
  .DW(DW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .RANGE_CHECK(RANGE_CHECK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_dir      (req_dir),
  .req_operand  (req_operand),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_range_err(rsp_range_err),
  .rsp_div_err  (rsp_div_err),
  .busy         (busy),
  .div_done     (div_done)
);

// File: tb/thermcode_conv_test.sv
`timescale 1ns/1ps
module thermcode_conv_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [15:0] cfg_fuse = '0, cfg_fallback = '0;
  logic [7:0]  cfg_fuse_min = '0, cfg_fuse_max = '0;
  logic [7:0]  cfg_ref_lo = '0, cfg_ref_hi = '0, cfg_offset = '0;
  logic        req_valid = 1'b0, req_dir = 1'b0;
  logic [7:0]  req_operand = '0;
  logic        req_ready, rsp_valid, rsp_range_err, rsp_div_err, busy;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    data;
    bit    rerr;
    bit    derr;
    string tag;
  } exp_t;
  exp_t sb[$];

  // model of the captured configuration
  int m_mode, m_e1, m_e2, m_t1, m_t2, m_ofs;

  always #2.5 clk = ~clk;

  thermcode_conv uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_fuse(cfg_fuse), .cfg_fallback(cfg_fallback),
    .cfg_fuse_min(cfg_fuse_min), .cfg_fuse_max(cfg_fuse_max),
    .cfg_ref_lo(cfg_ref_lo), .cfg_ref_hi(cfg_ref_hi), .cfg_offset(cfg_offset),
    .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir),
    .req_operand(req_operand), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_range_err(rsp_range_err),
    .rsp_div_err(rsp_div_err), .busy(busy)
  );

  function automatic int sat(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int model(int dir, int op, output bit derr);
    int d;
    derr = 1'b0;
    if (m_mode == 2) begin
      d = dir ? (m_e2 - m_e1) : (m_t2 - m_t1);
      if (d == 0) begin derr = 1'b1; return 0; end
      if (dir) return sat((op - m_e1) * (m_t2 - m_t1) / d + m_t1);
      return sat((op - m_t1) * (m_e2 - m_e1) / d + m_e1);
    end
    if (m_mode == 1) return dir ? sat(op - m_e1 + m_t1) : sat(op + m_e1 - m_t1);
    return dir ? sat(op - m_ofs) : sat(op + m_ofs);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input int mode, input int fuse, input int spare,
                          input int mn, input int mx, input int t1,
                          input int t2, input int ofs);
    int r1, r2;
    while (busy) @(negedge clk);
    cfg_mode = 2'(mode); cfg_fuse = 16'(fuse); cfg_fallback = 16'(spare);
    cfg_fuse_min = 8'(mn); cfg_fuse_max = 8'(mx);
    cfg_ref_lo = 8'(t1); cfg_ref_hi = 8'(t2); cfg_offset = 8'(ofs);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    r1 = fuse & 255;
    r2 = (fuse >> 8) & 255;
    m_e1 = (r1 == 0 || r1 < mn || r1 > mx) ? (spare & 255) : r1;
    m_e2 = (r2 == 0) ? ((spare >> 8) & 255) : r2;
    m_mode = mode; m_t1 = t1; m_t2 = t2; m_ofs = ofs;
  endtask

  // driver: push expectation, then present the request
  task automatic send(input int dir, input int op, input string tag);
    exp_t e;
    bit de;
    e.data = model(dir, op, de);
    e.derr = de;
    e.rerr = (dir == 1) && (op < 75 || op > 175);
    e.tag  = tag;
    sb.push_back(e);
    while (!req_ready) @(negedge clk);
    req_dir = dir[0]; req_operand = 8'(op); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R11 busy after accept", {31'd0, req_ready}, 0);
  endtask

  // monitor: compare at each response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected response", int'(rsp_data), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(rsp_data) == e.data && rsp_div_err == e.derr && rsp_range_err == e.rerr,
              e.tag, int'({rsp_div_err, rsp_range_err, rsp_data}),
              (int'(e.derr) << 9) | (int'(e.rerr) << 8) | e.data);
      end
    end
  end

  // back-pressure pattern, changed just after the rising edge
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      rsp_ready = (n % 5) < 2;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !busy, "R12 reset state",
          int'({req_ready, rsp_valid, busy}), 4);

    // fixed offset
    load_cfg(0, 16'h0000, 16'h0000, 0, 255, 0, 0, 50);
    send(0, 25, "R4 fixed fwd");
    send(1, 120, "R4 fixed inv");
    send(1, 30, "R8 clamp low / R10 below window");
    send(0, 240, "R8 clamp high");
    send(1, 75, "R10 window low edge");
    send(1, 175, "R10 window high edge");
    send(1, 176, "R10 above window");
    send(1, 74, "R10 below window");
    send(0, 10, "R10 forward never flags");
    load_cfg(3, 16'h0000, 16'h0000, 0, 255, 0, 0, 7);
    send(0, 100, "R4 mode 11 fixed");

    // one-point and E1 validation
    load_cfg(1, 16'h003C, 16'h002D, 40, 120, 25, 85, 0);
    send(0, 30, "R5 one-point fwd");
    send(1, 100, "R5 one-point inv");
    load_cfg(1, 16'h0000, 16'h002D, 40, 120, 25, 85, 0);
    send(0, 30, "R2 E1 zero uses spare");
    load_cfg(1, 16'h001E, 16'h002D, 40, 120, 25, 85, 0);
    send(0, 30, "R2 E1 below min uses spare");
    load_cfg(1, 16'h0082, 16'h002D, 40, 120, 25, 85, 0);
    send(0, 30, "R2 E1 above max uses spare");
    load_cfg(1, 16'h0028, 16'h002D, 40, 120, 25, 85, 0);
    send(0, 30, "R2 E1 at min kept");

    // two-point
    load_cfg(2, 16'h8C32, 16'hAA2D, 10, 200, 25, 85, 0);
    send(0, 60, "R6 two-point fwd");
    send(0, 10, "R6 negative quotient truncates");
    send(1, 20, "R7 two-point inv");
    send(1, 0, "R8 two-point clamp low");
    send(0, 255, "R8 two-point clamp high");
    send(1, 150, "R7 two-point inv in window");
    load_cfg(2, 16'h0032, 16'hAA2D, 10, 200, 25, 85, 0);
    send(1, 120, "R3 E2 zero uses spare");
    send(0, 40, "R3 E2 spare fwd");

    // zero divisor
    load_cfg(2, 16'h3232, 16'hAA2D, 10, 200, 25, 85, 0);
    send(1, 100, "R9 E2 equals E1");
    load_cfg(2, 16'h8C32, 16'hAA2D, 10, 200, 40, 40, 0);
    send(0, 60, "R9 T2 equals T1");
    send(1, 60, "R9 other direction divides");

    // configuration pins ignored without a load, and a load while busy
    load_cfg(1, 16'h003C, 16'h002D, 40, 120, 25, 85, 0);
    cfg_fuse = 16'h0050; cfg_mode = 2'b00; cfg_offset = 8'd99;
    send(0, 50, "R1 pins ignored without load");
    send(0, 70, "R1 in flight");
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    send(0, 80, "R1 load while busy ignored");

    for (int i = 0; i < 2000 && (sb.size() != 0 || busy); i++) @(negedge clk);
    check(sb.size() == 0, "R11 all responses delivered", sb.size(), 0);
    finish_run();
  end

endmodule